// File: doc/BRIEF.md
# Network LED Status Source Selector

This block holds a small host-writable LED control register for a multi-port Ethernet controller and turns it into the drive for one status LED. Each enable bit in the register picks one status condition as a source for the LED: 100 Mbps operation, MII-selected state, wakeup-frame detection, or full-duplex link. The full-duplex condition depends on which network port is active. The enabled conditions are ORed together. A polarity bit then sets the output level, and the value before polarity can be read back through a read-only status bit.

A second pin, the transceiver-power LED, is driven by a control bit, but only while the AUI port is the active port. On any other port it stays at its deasserted level. The polarity bit also sets the level of this pin. The control bits clear only on hard reset. Soft reset and the stop flag leave them unchanged, and the host can read and write the register at any time. Hard reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `led_status_sel`

## Requirements
- R1: While hard reset is low, and after it is released, every control bit reads 0. Then rd_data is 8'h00, led_out is 0 and xcvr_led is 0.
- R2: A write with wr_en high loads wr_data[5:0] into the control bits on the next clock edge. rd_data[5:0] returns those bits and rd_data[6] reads 0. Written values of bits 6 and 7 have no effect, and rd_data[7] is the composite status bit.
- R3: Soft reset and the stop flag, high alone or together, change no control bit.
- R4: With bit 0 (100 Mbps enable) set, the 100 Mbps mode input is a source.
- R5: With bit 1 (MII-selected enable) set, the source is true when the management state machine selects the MII, or when automatic selection is off and the manual port field is 2'b10 (MII).
- R6: With bit 2 (wakeup enable) set, the source is wake_mode AND wake_det.
- R7: With bit 3 (full-duplex enable) set, the source depends on the active port. Port encoding 2'b00 is 10BASE-T, where the source is link_pass AND fdx_en. Encoding 2'b01 is AUI, where the source is fdx_en AND aui_fdx. Encoding 2'b10 is MII, where the source is fdx_en. Encoding 2'b11 gives 0.
- R8: The composite is the OR of all enabled sources and appears on rd_data[7]. led_out is the composite XOR bit 5 (polarity), so with polarity 0 the LED is active-high.
- R9: While the AUI port is active, bit 4 (transceiver control) asserts xcvr_led when it is 1 and deasserts it when it is 0. The asserted level is NOT polarity.
- R10: On any port other than AUI, xcvr_led sits at its deasserted level, which equals polarity, whatever bit 4 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active-low |
| soft_rst | input | 1 | Soft reset; does not affect the register |
| stop | input | 1 | Stop flag; does not affect the register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value, with the status bit in bit 7 |
| fast_mode | input | 1 | Controller running at 100 Mbps |
| msm_sel_mii | input | 1 | Management state machine selects the MII |
| auto_sel_en | input | 1 | Automatic port selection enabled |
| man_port_sel | input | 2 | Manual port-select field |
| act_port | input | 2 | Active network port |
| link_pass | input | 1 | 10BASE-T link pass |
| fdx_en | input | 1 | Full-duplex enable |
| aui_fdx | input | 1 | AUI full-duplex enable |
| wake_mode | input | 1 | Wakeup frame mode enabled |
| wake_det | input | 1 | Wakeup frame detected |
| led_out | output | 1 | Composite LED output after polarity |
| xcvr_led | output | 1 | Transceiver-power LED pin |

## Verification
A register write can land in the same cycle as a soft reset or a stop request, and that is the collision that matters most. The bench raises soft_rst and stop while it writes and while it does not. It then judges, on the following cycle, that the written value is read back and that the previous value is kept when there is no write. The other same-cycle overlap is a change of active port during a write of the transceiver-control bit. The bench compares xcvr_led and led_out on every cycle against a model that works out the port-dependent sources directly from the requirements.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;
  localparam int REG_W   = 8;
  localparam int CTRL_W  = 6;
  localparam int NUM_SRC = 4;
  localparam int B_FAST  = 0;
  localparam int B_MII   = 1;
  localparam int B_WAKE  = 2;
  localparam int B_FDX   = 3;
  localparam int B_XCVR  = 4;
  localparam int B_POL   = 5;

  typedef enum logic [1:0] {
    PORT_TP   = 2'b00,
    PORT_AUI  = 2'b01,
    PORT_MII  = 2'b10,
    PORT_NONE = 2'b11
  } port_e;
endpackage

// File: rtl/led_ctrl_reg.sv
module led_ctrl_reg #(
  parameter int REG_W  = 8,
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  // R3
  soft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_rst || stop) && !wr_en) |=> $stable(ctrl_q));

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == $past(wr_data[CTRL_W-1:0])));
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import led_sel_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0] src_en,
  input  logic             fast_mode,
  input  logic             msm_sel_mii,
  input  logic             auto_sel_en,
  input  logic [1:0]       man_port_sel,
  input  logic [1:0]       act_port,
  input  logic             link_pass,
  input  logic             fdx_en,
  input  logic             aui_fdx,
  input  logic             wake_mode,
  input  logic             wake_det,
  output logic [N_SRC-1:0] src_hit,
  output logic             composite
);
  logic [N_SRC-1:0] cond;
  logic             mii_sel;
  logic             fdx_cond;

  assign mii_sel = msm_sel_mii ||
                   (!auto_sel_en && (port_e'(man_port_sel) == PORT_MII));

  always_comb begin
    case (port_e'(act_port))
      PORT_TP:  fdx_cond = link_pass && fdx_en;
      PORT_AUI: fdx_cond = fdx_en && aui_fdx;
      PORT_MII: fdx_cond = fdx_en;
      default:  fdx_cond = 1'b0;
    endcase
  end

  always_comb begin
    cond         = '0;
    cond[B_FAST] = fast_mode;
    cond[B_MII]  = mii_sel;
    cond[B_WAKE] = wake_mode && wake_det;
    cond[B_FDX]  = fdx_cond;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign src_hit[i] = src_en[i] & cond[i];
  end

  assign composite = |src_hit;
endmodule

// File: rtl/led_pin_drv.sv
module led_pin_drv
  import led_sel_pkg::*;
(
  input  logic       composite,
  input  logic       pol,
  input  logic       xcvr_ctl,
  input  logic [1:0] act_port,
  output logic       led_out,
  output logic       xcvr_led
);
  logic xcvr_on;

  assign xcvr_on  = (port_e'(act_port) == PORT_AUI) && xcvr_ctl;
  assign led_out  = composite ^ pol;
  assign xcvr_led = xcvr_on ^ pol;
endmodule

// File: rtl/led_status_sel.sv
module led_status_sel
  import led_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             stop,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             fast_mode,
  input  logic             msm_sel_mii,
  input  logic             auto_sel_en,
  input  logic [1:0]       man_port_sel,
  input  logic [1:0]       act_port,
  input  logic             link_pass,
  input  logic             fdx_en,
  input  logic             aui_fdx,
  input  logic             wake_mode,
  input  logic             wake_det,
  output logic             led_out,
  output logic             xcvr_led
);
  localparam int PAD_W = REG_W - CTRL_W - 1;

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_SRC-1:0] src_hit;
  logic               composite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  led_ctrl_reg #(.REG_W(REG_W), .CTRL_W(CTRL_W)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .soft_rst(soft_rst), .stop(stop),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  led_src_mux #(.N_SRC(NUM_SRC)) u_src (
    .src_en(ctrl_q[NUM_SRC-1:0]), .fast_mode(fast_mode),
    .msm_sel_mii(msm_sel_mii), .auto_sel_en(auto_sel_en),
    .man_port_sel(man_port_sel), .act_port(act_port),
    .link_pass(link_pass), .fdx_en(fdx_en), .aui_fdx(aui_fdx),
    .wake_mode(wake_mode), .wake_det(wake_det),
    .src_hit(src_hit), .composite(composite)
  );

  led_pin_drv u_pin (
    .composite(composite), .pol(ctrl_q[B_POL]), .xcvr_ctl(ctrl_q[B_XCVR]),
    .act_port(act_port), .led_out(led_out), .xcvr_led(xcvr_led)
  );

  assign rd_data = {composite, {PAD_W{1'b0}}, ctrl_q};

  // R10
  xcvr_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_port != 2'(PORT_AUI)) |-> (xcvr_led == ctrl_q[B_POL]));

  // R8
  led_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_q[NUM_SRC-1:0] == '0) |-> (led_out == ctrl_q[B_POL]));

  // R7
  fdx_tp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_port == 2'(PORT_TP) && !link_pass && !fast_mode &&
     (ctrl_q[NUM_SRC-1:0] == (NUM_SRC'(1) << B_FDX))) |-> !rd_data[REG_W-1]);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    (!rst_int_n) |-> (ctrl_q == '0));
endmodule

// File: tb/led_status_sel_test.sv
module led_status_sel_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, soft_rst = 0, stop = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic fast_mode = 0, msm_sel_mii = 0, auto_sel_en = 1, link_pass = 0;
  logic fdx_en = 0, aui_fdx = 0, wake_mode = 0, wake_det = 0;
  logic [1:0] man_port_sel = 0, act_port = 0;
  logic led_out, xcvr_led;

  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";
  logic [5:0] mreg = 0;
  logic checking = 0;

  always #(CLK_P/2) clk = ~clk;

  led_status_sel uut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mreg <= 0;
    else if (wr_en) mreg <= wr_data[5:0];
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic src, fd, xl, mii;
    cyc++;
    if (checking) begin
      fd = 0;
      if (act_port == 2'b00) fd = link_pass & fdx_en;
      else if (act_port == 2'b01) fd = fdx_en & aui_fdx;
      else if (act_port == 2'b10) fd = fdx_en;
      mii = msm_sel_mii | (!auto_sel_en && man_port_sel == 2'b10);
      src = 0;
      if (mreg[0] && fast_mode) src = 1;
      if (mreg[1] && mii) src = 1;
      if (mreg[2] && wake_mode && wake_det) src = 1;
      if (mreg[3] && fd) src = 1;
      xl = (act_port == 2'b01 && mreg[4]) ? !mreg[5] : mreg[5];
      chk({phase, " rd_data"}, rd_data, {src, 1'b0, mreg});
      chk({phase, " led_out"}, {7'd0, led_out}, {7'd0, src ^ mreg[5]});
      chk({phase, " xcvr_led"}, {7'd0, xcvr_led}, {7'd0, xl});
    end
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(logic [7:0] d);
    step(); wr_en = 1; wr_data = d;
    step(); wr_en = 0;
  endtask

  task automatic rnd_status();
    {fast_mode, msm_sel_mii, auto_sel_en, link_pass} = 4'($urandom);
    {fdx_en, aui_fdx, wake_mode, wake_det} = 4'($urandom);
    man_port_sel = 2'($urandom);
    act_port = 2'($urandom);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    checking = 1;
    // R1: cleared state under busy status
    fast_mode = 1; wake_mode = 1; wake_det = 1; act_port = 2'b01;
    repeat (2) step();
    // R2: write and read, including read-only bits
    phase = "R2";
    wr(8'hFF); step(); wr(8'h55); step(); wr(8'h80); step();
    // R3: soft reset and stop
    phase = "R3";
    wr(8'h1B);
    soft_rst = 1; repeat (3) step();
    stop = 1; repeat (3) step();
    soft_rst = 0; repeat (3) step();
    wr_en = 1; wr_data = 8'h26; step(); wr_en = 0; stop = 0; step();
    // R4: speed source
    phase = "R4";
    wr(8'h01);
    for (int i = 0; i < 8; i++) begin rnd_status(); fast_mode = i[0]; step(); end
    // R5: MII-selected source
    phase = "R5";
    wr(8'h02); fast_mode = 1;
    for (int i = 0; i < 16; i++) begin
      {msm_sel_mii, auto_sel_en, man_port_sel} = 4'(i); step();
    end
    // R6: wakeup source
    phase = "R6";
    wr(8'h04);
    for (int i = 0; i < 4; i++) begin {wake_mode, wake_det} = 2'(i); step(); end
    // R7: full-duplex per port
    phase = "R7";
    wr(8'h08);
    for (int i = 0; i < 32; i++) begin
      {act_port, link_pass, fdx_en, aui_fdx} = 5'(i); step();
    end
    // R8: OR of sources and polarity
    phase = "R8";
    for (int i = 0; i < 64; i++) begin
      if (i % 8 == 0) wr(8'($urandom) & 8'h2F);
      rnd_status(); step();
    end
    // R9: transceiver pin on AUI
    phase = "R9";
    act_port = 2'b01;
    wr(8'h10); step(); wr(8'h30); step(); wr(8'h20); step(); wr(8'h00); step();
    wr_en = 1; wr_data = 8'h10; act_port = 2'b00; step();
    wr_en = 0; act_port = 2'b01; step();
    // R10: transceiver pin off other ports
    phase = "R10";
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) wr(i[2] ? 8'h30 : 8'h10);
      act_port = (i[0]) ? 2'b10 : 2'b00; step(); act_port = 2'b11; step();
    end
    // R1: hard reset clears
    phase = "R1";
    wr(8'h3F); step();
    checking = 0; rst_n = 0; #2;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 led_out", {7'd0, led_out}, 8'h00);
    chk("R1 xcvr_led", {7'd0, xcvr_led}, 8'h00);
    step(); rst_n = 1; repeat (4) step();
    checking = 1; repeat (2) step();
    checking = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule